// File: doc/BRIEF.md
# Lockable Multi-Master Bus Arbiter

This block decides which of several masters owns a shared on-chip bus. Every master raises its own request line and receives its own grant line. The arbiter watches the bus select line and the transfer-acknowledge line to tell when the bus may change hands. The bus may change hands when the bus is idle (select low) or when the current transfer is completing (acknowledge high). At those points the lowest-indexed requesting master wins. Grants are registered, so a decision made at a clock edge shows on the grant outputs after that edge.

A master that holds the grant can pin the bus to itself by raising its lock line. While the owner's lock line is high, its grant is kept whatever the other requests, the priority order, or the state of select and acknowledge. A lock line raised by a master that is not granted has no effect. Each master also receives a combinational pending output. This output is high when any other master is requesting. A master doing a long locked sequence uses it to decide when to let the bus go. A granted master is expected to raise select in the cycle after it sees its grant.

Top module: `bus_arb_lock`

## Requirements
- R1: While reset is asserted, and after release until a request is seen in an arbitration cycle, every grant output is low.
- R2: In a valid arbitration cycle without an active lock, the grant after the next rising edge goes to the requesting master with the lowest index (bit 0 is highest priority).
- R3: A cycle is a valid arbitration cycle when select is low or transfer-acknowledge is high; when select is high and acknowledge is low, the grant is unchanged after the edge.
- R4: When the granted master has its lock bit high, its grant is kept after the edge regardless of requests, select or acknowledge; lock bits of masters that are not granted have no effect.
- R5: At most one grant output is high at any time.
- R6: Pending output bit i is high exactly when some master other than i has its request high, in the same cycle and with no register in between.
- R7: In a valid arbitration cycle with no request and no active lock, all grants go low after the edge.
- R8: Once the owner drops its lock bit, the next valid arbitration cycle arbitrates again by priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-stage synchronizer |
| req_i | input | N_MASTERS | Per-master bus request |
| lock_i | input | N_MASTERS | Per-master lock request, honoured only for the granted master |
| sel_i | input | 1 | Bus select, high while a transfer is in progress |
| xfer_ack_i | input | 1 | Transfer acknowledge, high in the cycle a transfer completes |
| gnt_o | output | N_MASTERS | Registered per-master grant, one-hot or zero |
| pend_o | output | N_MASTERS | Per-master flag that another master is requesting |

## Verification
The assertions assume only that all inputs are synchronous to the clock and settled before each rising edge. They do not assume that masters behave well. Select, acknowledge and lock may take any value in any cycle. The stimulus uses this freedom on purpose. Directed steps raise lock bits on masters that are not granted and raise locks when nobody holds the bus. A pseudo-random phase then drives requests, locks, select and acknowledge independently, including acknowledge with select low. Every property therefore has to hold over arbitrary master behaviour.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  // Classification of the current cycle for the grant register.
  typedef enum logic [1:0] {
    ARB_HOLD_LOCK = 2'd0,  // owner has its lock bit up: keep grant
    ARB_OPEN      = 2'd1,  // bus idle or transfer ending: re-arbitrate
    ARB_BUSY      = 2'd2   // transfer in flight: keep grant
  } arb_phase_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/bus_arb_rst_sync.sv
module bus_arb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bus_arb_phase.sv
module bus_arb_phase
  import bus_arb_pkg::*;
#(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] gnt_q,
  input  logic [N_MASTERS-1:0] lock_i,
  input  logic                 sel_i,
  input  logic                 xfer_ack_i,
  output arb_phase_e           phase_o
);

  logic owner_locked;
  logic arb_window;

  assign owner_locked = |(gnt_q & lock_i);
  assign arb_window   = !sel_i || xfer_ack_i;

  always_comb begin
    if (owner_locked) begin
      phase_o = ARB_HOLD_LOCK;
    end else if (arb_window) begin
      phase_o = ARB_OPEN;
    end else begin
      phase_o = ARB_BUSY;
    end
  end

endmodule

// File: rtl/bus_arb_prio.sv
module bus_arb_prio #(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] pick_o
);

  // blocked[i]: some master with a lower index is requesting
  logic [N_MASTERS-1:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_pick
    if (i > 0) begin : g_chain
      assign blocked[i] = blocked[i-1] | req_i[i-1];
    end
    assign pick_o[i] = req_i[i] & ~blocked[i];
  end

  // R5: the picker never selects two masters
  always_comb begin
    a_r5_pick_onehot: assert ($onehot0(pick_o));
  end

endmodule

// File: rtl/bus_arb_pend.sv
module bus_arb_pend #(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic [N_MASTERS-1:0] req_i,
  output logic [N_MASTERS-1:0] pend_o
);

  localparam logic [N_MASTERS-1:0] ONE = N_MASTERS'(1);

  for (genvar i = 0; i < N_MASTERS; i++) begin : g_pend
    assign pend_o[i] = |(req_i & ~(ONE << i));
  end

  // R6: two or more requesters means everyone sees a competitor;
  // no requester means nobody does
  always_comb begin
    if ($countones(req_i) >= 2) begin
      a_r6_all_pend: assert (&pend_o);
    end
    if (req_i == '0) begin
      a_r6_none_pend: assert (pend_o == '0);
    end
  end

endmodule

// File: rtl/bus_arb_lock.sv
module bus_arb_lock
  import bus_arb_pkg::*;
#(
  parameter int unsigned N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] lock_i,
  input  logic                 sel_i,
  input  logic                 xfer_ack_i,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic [N_MASTERS-1:0] pend_o
);

  logic                 rst_sync_n;
  logic [N_MASTERS-1:0] gnt_q;
  logic [N_MASTERS-1:0] gnt_d;
  logic                 gnt_en;
  logic [N_MASTERS-1:0] pick;
  arb_phase_e           phase;

  bus_arb_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bus_arb_phase #(.N_MASTERS(N_MASTERS)) u_phase (
    .gnt_q      (gnt_q),
    .lock_i     (lock_i),
    .sel_i      (sel_i),
    .xfer_ack_i (xfer_ack_i),
    .phase_o    (phase)
  );

  bus_arb_prio #(.N_MASTERS(N_MASTERS)) u_prio (
    .req_i  (req_i),
    .pick_o (pick)
  );

  bus_arb_pend #(.N_MASTERS(N_MASTERS)) u_pend (
    .req_i  (req_i),
    .pend_o (pend_o)
  );

  // Next-state: only an open arbitration cycle loads a new grant
  always_comb begin
    gnt_en = 1'b0;
    gnt_d  = gnt_q;
    if (phase == ARB_OPEN) begin
      gnt_en = 1'b1;
      gnt_d  = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;

  // R1: grants are low while the synchronized reset is active
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      a_r1_reset_idle: assert (gnt_o == '0);
    end
  end

  // R5: never more than one owner
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(gnt_o));

  // R4: the owner holding its lock bit keeps the bus
  a_r4_lock_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(gnt_o & lock_i)) |=> (gnt_o == $past(gnt_o)));

  // R3: a transfer in flight without acknowledge freezes the grant
  a_r3_busy_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_i && !xfer_ack_i) |=> $stable(gnt_o));

  // R2: after an unlocked arbitration cycle only a requester is granted
  a_r2_only_requester: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(|(gnt_o & lock_i)) && (!sel_i || xfer_ack_i)) |=>
      ((gnt_o & ~$past(req_i)) == '0));

  // R2: an unlocked arbitration cycle with any request yields an owner
  a_r2_someone_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(|(gnt_o & lock_i)) && (!sel_i || xfer_ack_i) && (|req_i)) |=> (|gnt_o));

  // R7: nobody requesting in an open cycle parks the bus with no owner
  a_r7_park_empty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!(|(gnt_o & lock_i)) && (!sel_i || xfer_ack_i) && (req_i == '0)) |=>
      (gnt_o == '0));

endmodule

// File: tb/bus_arb_lock_bench.sv
`timescale 1ns/1ps
module bus_arb_lock_bench;

  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] lock;
  logic         sel;
  logic         ack;
  logic [N-1:0] gnt;
  logic [N-1:0] pend;

  int           n_tests;
  int           n_fail;
  logic [N-1:0] exp_gnt;
  bit           done;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  bus_arb_lock #(.N_MASTERS(N)) u_bus_arb_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req),
    .lock_i     (lock),
    .sel_i      (sel),
    .xfer_ack_i (ack),
    .gnt_o      (gnt),
    .pend_o     (pend)
  );

  function automatic logic [N-1:0] ref_pick(logic [N-1:0] r);
    for (int i = 0; i < N; i++) begin
      if (r[i]) return N'(1) << i;
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] ref_pend(logic [N-1:0] r);
    logic [N-1:0] p;
    p = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (j != i && r[j]) p[i] = 1'b1;
      end
    end
    return p;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, check pending combinationally,
  // advance the reference at the rising edge, check grants just after it.
  task automatic step(string tag, logic [N-1:0] r, logic [N-1:0] l,
                      logic s, logic a);
    bit locked;
    @(negedge clk);
    req = r; lock = l; sel = s; ack = a;
    #1;
    check("R6 pending", pend, ref_pend(r));
    @(posedge clk);
    locked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (exp_gnt[i] && l[i]) locked = 1'b1;
    end
    if (!locked && (!s || a)) exp_gnt = ref_pick(r);
    #1;
    check(tag, gnt, exp_gnt);
    check("R5 onehot", N'($onehot0(gnt)), N'(1));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    n_tests = 0; n_fail = 0; done = 1'b0;
    exp_gnt = '0;
    rst_n = 1'b0; req = '0; lock = '0; sel = 1'b0; ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", gnt, '0);
    // requests during reset must not be granted
    req = 4'b1111;
    @(negedge clk);
    check("R1 in reset with requests", gnt, '0);
    req = '0;
    rst_n = 1'b1;
    step("R1 after release", '0, '0, 1'b0, 1'b0);
    step("R1 after release", '0, '0, 1'b0, 1'b0);
    step("R1 after release", '0, '0, 1'b0, 1'b0);

    step("R2 single requester", 4'b0100, '0, 1'b0, 1'b0);
    step("R3 busy hold",        4'b0101, '0, 1'b1, 1'b0);
    step("R3 busy hold",        4'b0111, '0, 1'b1, 1'b0);
    step("R3 ack rearbitrates", 4'b0111, '0, 1'b1, 1'b1);
    step("R4 owner lock busy",  4'b0111, 4'b0001, 1'b1, 1'b0);
    step("R4 owner lock ack",   4'b1110, 4'b0001, 1'b1, 1'b1);
    step("R4 owner lock idle",  4'b1110, 4'b0001, 1'b0, 1'b0);
    step("R8 lock released",    4'b1110, 4'b0000, 1'b0, 1'b0);
    step("R4 non-owner lock",   4'b1100, 4'b1000, 1'b0, 1'b0);
    step("R7 no requests",      4'b0000, 4'b0000, 1'b0, 1'b0);
    step("R7 locks no owner",   4'b0000, 4'b1111, 1'b0, 1'b0);
    step("R2 top index",        4'b1000, '0, 1'b0, 1'b0);
    step("R2 preempt idle",     4'b1010, '0, 1'b0, 1'b0);
    step("R2 ack without sel",  4'b1011, '0, 1'b0, 1'b1);

    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] rr, ll;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rr = lfsr[3:0];
      ll = lfsr[7:4] & {N{lfsr[8]}};
      step("R2 random", rr, ll, lfsr[9], lfsr[11] & lfsr[12]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule